// File: doc/BRIEF.md
# Dual sliding window scheduler

This control unit sequences two max-log-MAP recursions that run side by side over two adjacent windows of `WIN_LEN` symbols each, both extended by a learning stretch of `LEARN_LEN` steps. It does not compute any metrics. Instead it issues a step index, metric-initialisation strobes and per-window LLR valid flags with bit indices. The datapath around it uses these to drive its add-compare-select units and metric memories.

A pair is accepted only from idle, and only when the available symbol count reaches two windows. The forward pass runs first. Window-2's forward metrics, computed across the shared boundary, later seed window-1's backward recursion. This stands in for trellis termination. The backward pass then walks down and produces one LLR per window per step. A one-cycle pair-done marker follows, and then the unit waits for the next two windows. Window-1's forward metrics start fresh (state 0 at zero, all others at -128) on the first pair after reset or when a new frame is flagged. In every other case they carry over from the previous pair.

Top module: `dsw_sched`

## Requirements
- R1: While reset is asserted and just after it, busy, pair_done, fwd_act, bwd_act, fwd_load, bwd_load, llr_vld1 and llr_vld2 are all low.
- R2: A start pulse is taken only when the unit is idle and sym_count >= 2*WIN_LEN. Otherwise it is ignored and busy stays low.
- R3: In the cycle after an accepted start, the forward phase begins. It lasts WIN_LEN+LEARN_LEN-1 cycles, with step counting 1, 2, ... up to WIN_LEN+LEARN_LEN-1 and fwd_idx2 = step + WIN_LEN.
- R4: fwd_load is high only on the first forward cycle. w1_fresh is high with it when this is the first pair since reset, or when new_frame was high with the accepted start. Otherwise w1_fresh stays low, meaning window-1 carries its final forward metrics over.
- R5: The backward phase follows the last forward cycle directly. step counts down from WIN_LEN+LEARN_LEN-1 to 1, and bwd_load is high only on the first backward cycle (window-2 backward start index 2*WIN_LEN+LEARN_LEN-1).
- R6: llr_vld1 is high exactly in the backward cycles with step <= WIN_LEN, with llr_idx1 = step-1, so it covers WIN_LEN-1 down to 0.
- R7: llr_vld2 is high in the same cycles as llr_vld1, with llr_idx2 = step-1+WIN_LEN, so it covers 2*WIN_LEN-1 down to WIN_LEN.
- R8: pair_done is high for exactly one cycle, right after the backward step 1 cycle, with busy still high. The next cycle is idle.
- R9: A start or new_frame value presented while busy has no effect on the running pair, and it does not change whether the next pair starts fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to decode the next window pair |
| new_frame | input | 1 | Sampled with an accepted start; forces fresh window-1 forward metrics |
| sym_count | input | IW | Number of received symbols available |
| busy | output | 1 | Pair in progress (forward, backward or done cycle) |
| pair_done | output | 1 | One-cycle marker at the end of a pair |
| fwd_act | output | 1 | Forward recursion step active |
| bwd_act | output | 1 | Backward recursion step active |
| step | output | IW | Current window-1 trellis step |
| fwd_idx2 | output | IW | Window-2 trellis index (step + WIN_LEN) |
| fwd_load | output | 1 | Initialise forward metrics (window-2 all zero) |
| w1_fresh | output | 1 | With fwd_load: window-1 starts from state 0 instead of carrying |
| bwd_load | output | 1 | Load both backward metric sets from forward metrics of the same index |
| llr_vld1 | output | 1 | Window-1 LLR valid |
| llr_idx1 | output | IW | Window-1 LLR bit index |
| llr_vld2 | output | 1 | Window-2 LLR valid |
| llr_idx2 | output | IW | Window-2 LLR bit index |

## Verification
The hardest case to reach from the ports is whether the decision between fresh and carried metrics is right. Whether the decision is right only shows one whole pair later, as w1_fresh on the next fwd_load. To reach it, the stimulus chains pairs back to back: an accepted pair, a pair whose start came with new_frame, rejected requests carrying new_frame, and a start plus new_frame pulse placed in the middle of a running pair. It then checks that only the legitimate causes turn w1_fresh on. A reset in the middle of a pair confirms that the carry history is cleared.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_BWD  = 2'd2,
    ST_DONE = 2'd3
  } dsw_state_e;
endpackage

// File: rtl/dsw_step_cnt.sv
module dsw_step_cnt #(
  parameter int IW   = 5,
  parameter int LAST = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_first,
  input  logic          ld_last,
  input  logic          up_en,
  input  logic          dn_en,
  output logic [IW-1:0] step
);
  logic [IW-1:0] step_nxt;

  always_comb begin
    step_nxt = step;
    if (ld_first)      step_nxt = IW'(1);
    else if (ld_last)  step_nxt = IW'(LAST);
    else if (up_en)    step_nxt = step + IW'(1);
    else if (dn_en)    step_nxt = step - IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= '0;
    else if (ld_first || ld_last || up_en || dn_en) step <= step_nxt;
  end
endmodule

// File: rtl/dsw_fsm.sv
module dsw_fsm
  import dsw_pkg::*;
#(
  parameter int IW        = 5,
  parameter int WIN_LEN   = 8,
  parameter int LEARN_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          new_frame,
  input  logic [IW-1:0] sym_count,
  input  logic [IW-1:0] step,
  output dsw_state_e    state,
  output logic          ld_first,
  output logic          ld_last,
  output logic          up_en,
  output logic          dn_en,
  output logic          fresh_q
);
  localparam int LAST = WIN_LEN + LEARN_LEN - 1;
  localparam int NEED = 2 * WIN_LEN;

  dsw_state_e state_nxt;
  logic       accept;
  logic       carry_q;

  assign accept = (state == ST_IDLE) && start && (sym_count >= IW'(NEED));

  always_comb begin
    state_nxt = state;
    ld_first  = 1'b0;
    ld_last   = 1'b0;
    up_en     = 1'b0;
    dn_en     = 1'b0;
    unique case (state)
      ST_IDLE: if (accept) begin
        state_nxt = ST_FWD;
        ld_first  = 1'b1;
      end
      ST_FWD: if (step == IW'(LAST)) begin
        state_nxt = ST_BWD;
        ld_last   = 1'b1;
      end else begin
        up_en = 1'b1;
      end
      ST_BWD: if (step == IW'(1)) begin
        state_nxt = ST_DONE;
      end else begin
        dn_en = 1'b1;
      end
      ST_DONE: state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      fresh_q <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      state <= state_nxt;
      if (accept)            fresh_q <= new_frame | ~carry_q;
      if (state == ST_DONE)  carry_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dsw_llr_mask.sv
module dsw_llr_mask #(
  parameter int IW      = 5,
  parameter int WIN_LEN = 8
) (
  input  logic          bwd_act,
  input  logic [IW-1:0] step,
  output logic [1:0]    vld,
  output logic [IW-1:0] idx [2]
);
  for (genvar wi = 0; wi < 2; wi++) begin : g_win
    localparam int OFS = wi * WIN_LEN;
    assign vld[wi] = bwd_act && (step != '0) && (step <= IW'(WIN_LEN));
    assign idx[wi] = step - IW'(1) + IW'(OFS);
  end
endmodule

// File: rtl/dsw_sched.sv
module dsw_sched
  import dsw_pkg::*;
#(
  parameter int WIN_LEN   = 8,
  parameter int LEARN_LEN = 4,
  localparam int IW = $clog2(2 * WIN_LEN + LEARN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          new_frame,
  input  logic [IW-1:0] sym_count,
  output logic          busy,
  output logic          pair_done,
  output logic          fwd_act,
  output logic          bwd_act,
  output logic [IW-1:0] step,
  output logic [IW-1:0] fwd_idx2,
  output logic          fwd_load,
  output logic          w1_fresh,
  output logic          bwd_load,
  output logic          llr_vld1,
  output logic [IW-1:0] llr_idx1,
  output logic          llr_vld2,
  output logic [IW-1:0] llr_idx2
);
  localparam int LAST = WIN_LEN + LEARN_LEN - 1;

  dsw_state_e    state;
  logic          ld_first, ld_last, up_en, dn_en, fresh_q;
  logic [1:0]    vld;
  logic [IW-1:0] idx [2];

  dsw_fsm #(.IW(IW), .WIN_LEN(WIN_LEN), .LEARN_LEN(LEARN_LEN)) fsm_i (
    .clk(clk), .rst_n(rst_n), .start(start), .new_frame(new_frame),
    .sym_count(sym_count), .step(step), .state(state),
    .ld_first(ld_first), .ld_last(ld_last), .up_en(up_en), .dn_en(dn_en),
    .fresh_q(fresh_q)
  );

  dsw_step_cnt #(.IW(IW), .LAST(LAST)) cnt_i (
    .clk(clk), .rst_n(rst_n), .ld_first(ld_first), .ld_last(ld_last),
    .up_en(up_en), .dn_en(dn_en), .step(step)
  );

  dsw_llr_mask #(.IW(IW), .WIN_LEN(WIN_LEN)) mask_i (
    .bwd_act(bwd_act), .step(step), .vld(vld), .idx(idx)
  );

  assign fwd_act   = (state == ST_FWD);
  assign bwd_act   = (state == ST_BWD);
  assign pair_done = (state == ST_DONE);
  assign busy      = (state != ST_IDLE);
  assign fwd_idx2  = step + IW'(WIN_LEN);
  assign fwd_load  = fwd_act && (step == IW'(1));
  assign w1_fresh  = fwd_load && fresh_q;
  assign bwd_load  = bwd_act && (step == IW'(LAST));
  assign llr_vld1  = vld[0];
  assign llr_idx1  = idx[0];
  assign llr_vld2  = vld[1];
  assign llr_idx2  = idx[1];
endmodule

// File: rtl/dsw_sched_chk.sv
module dsw_sched_chk #(
  parameter int WIN_LEN   = 8,
  parameter int LEARN_LEN = 4,
  parameter int IW        = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          new_frame,
  input logic [IW-1:0] sym_count,
  input logic          busy,
  input logic          pair_done,
  input logic          fwd_act,
  input logic          bwd_act,
  input logic [IW-1:0] step,
  input logic          fwd_load,
  input logic          w1_fresh,
  input logic          bwd_load,
  input logic          llr_vld1,
  input logic [IW-1:0] llr_idx1,
  input logic          llr_vld2,
  input logic [IW-1:0] llr_idx2
);
  assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (sym_count < IW'(2 * WIN_LEN))) |=> !busy);

  assert_rise_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> fwd_load);

  assert_fwd_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_act && $past(fwd_act)) |-> (step == IW'($past(step) + 1'b1)));

  assert_fresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && new_frame && (sym_count >= IW'(2 * WIN_LEN))) |=> w1_fresh);

  assert_bwd_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fwd_act) |-> (bwd_act && bwd_load));

  assert_bwd_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bwd_act && $past(bwd_act)) |-> (step == IW'($past(step) - 1'b1)));

  assert_llr1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    llr_vld1 |-> (bwd_act && (llr_idx1 < IW'(WIN_LEN))));

  assert_llr2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    llr_vld2 |-> (llr_vld1 && (llr_idx2 >= IW'(WIN_LEN)) && (llr_idx2 < IW'(2 * WIN_LEN))));

  assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pair_done |=> (!busy && !pair_done));

  assert_done_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pair_done) |-> $past(bwd_act));
endmodule

bind dsw_sched dsw_sched_chk #(.WIN_LEN(WIN_LEN), .LEARN_LEN(LEARN_LEN), .IW(IW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .new_frame(new_frame),
  .sym_count(sym_count), .busy(busy), .pair_done(pair_done),
  .fwd_act(fwd_act), .bwd_act(bwd_act), .step(step), .fwd_load(fwd_load),
  .w1_fresh(w1_fresh), .bwd_load(bwd_load), .llr_vld1(llr_vld1),
  .llr_idx1(llr_idx1), .llr_vld2(llr_vld2), .llr_idx2(llr_idx2)
);

// File: tb/dsw_sched_tb.sv
`timescale 1ns/1ps
module dsw_sched_tb_top;
  localparam int W    = 8;
  localparam int G    = 4;
  localparam int IW   = $clog2(2 * W + G + 1);
  localparam int LAST = W + G - 1;
  localparam int NV   = 6;
  // columns: sym_count, new_frame, accepted, expected w1_fresh
  localparam int VEC [NV][4] = '{
    '{16, 0, 1, 1},
    '{16, 0, 1, 0},
    '{15, 0, 0, 0},
    '{20, 1, 1, 1},
    '{0,  1, 0, 0},
    '{17, 0, 1, 0}
  };

  logic clk, rst_n, start, new_frame;
  logic [IW-1:0] sym_count;
  logic busy, pair_done, fwd_act, bwd_act, fwd_load, w1_fresh, bwd_load, llr_vld1, llr_vld2;
  logic [IW-1:0] step, fwd_idx2, llr_idx1, llr_idx2;
  int total, bad;

  dsw_sched #(.WIN_LEN(W), .LEARN_LEN(G)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .new_frame(new_frame),
    .sym_count(sym_count), .busy(busy), .pair_done(pair_done),
    .fwd_act(fwd_act), .bwd_act(bwd_act), .step(step), .fwd_idx2(fwd_idx2),
    .fwd_load(fwd_load), .w1_fresh(w1_fresh), .bwd_load(bwd_load),
    .llr_vld1(llr_vld1), .llr_idx1(llr_idx1), .llr_vld2(llr_vld2), .llr_idx2(llr_idx2)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_chk(input string req);
    chk({req, " busy"}, int'(busy), 0);
    chk({req, " fwd_act"}, int'(fwd_act), 0);
    chk({req, " bwd_act"}, int'(bwd_act), 0);
    chk({req, " pair_done"}, int'(pair_done), 0);
    chk({req, " loads"}, int'(fwd_load | bwd_load), 0);
    chk({req, " llr_vld"}, int'(llr_vld1 | llr_vld2), 0);
  endtask

  task automatic run_pair(input int sc, input int nf, input int acc, input int fresh);
    @(negedge clk);
    start = 1'b1; sym_count = IW'(sc); new_frame = nf[0];
    @(negedge clk);
    start = 1'b0; new_frame = 1'b0;
    if (acc == 0) begin
      chk("R2 rejected start busy", int'(busy), 0);
      return;
    end
    for (int k = 1; k <= LAST; k++) begin
      chk("R3 fwd_act", int'(fwd_act), 1);
      chk("R3 step", int'(step), k);
      chk("R3 fwd_idx2", int'(fwd_idx2), k + W);
      chk("R4 fwd_load", int'(fwd_load), (k == 1) ? 1 : 0);
      chk("R4 w1_fresh", int'(w1_fresh), (k == 1) ? fresh : 0);
      if (k == 2) begin
        start = 1'b1; new_frame = 1'b1; sym_count = IW'(2 * W);
      end else begin
        start = 1'b0; new_frame = 1'b0;
      end
      @(negedge clk);
    end
    for (int k = LAST; k >= 1; k--) begin
      chk("R5 bwd_act", int'(bwd_act), 1);
      chk("R9 busy start ignored step", int'(step), k);
      chk("R5 bwd_load", int'(bwd_load), (k == LAST) ? 1 : 0);
      chk("R6 llr_vld1", int'(llr_vld1), (k <= W) ? 1 : 0);
      chk("R7 llr_vld2", int'(llr_vld2), (k <= W) ? 1 : 0);
      if (k <= W) begin
        chk("R6 llr_idx1", int'(llr_idx1), k - 1);
        chk("R7 llr_idx2", int'(llr_idx2), k - 1 + W);
      end
      @(negedge clk);
    end
    chk("R8 pair_done", int'(pair_done), 1);
    chk("R8 busy in done", int'(busy), 1);
    @(negedge clk);
    chk("R8 pair_done falls", int'(pair_done), 0);
    chk("R8 idle after done", int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; start = 1'b0; new_frame = 1'b0; sym_count = '0;
    repeat (3) @(negedge clk);
    idle_chk("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    idle_chk("R1 after reset");

    for (int v = 0; v < NV; v++)
      run_pair(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

    // reset in the middle of a pair clears the carry history
    @(negedge clk);
    start = 1'b1; sym_count = IW'(2 * W); new_frame = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    idle_chk("R1 async reset mid pair");
    @(negedge clk);
    rst_n = 1'b1;
    run_pair(2 * W, 0, 1, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule